// File: doc/BRIEF.md
# Hot-Swap Connection Sequencer

This block is the start-up and connection controller of a hot-pluggable two-wire bus buffer. It takes two supply-good flags, an enable input, and the synchronized data and clock levels from both sides of the buffer (side A is the input side, side B the output side). From these inputs it decides when the forwarding logic may join the two sides. It also decides when the precharge source may bias the pins, when the rise-time accelerators may fire, and whether the open-drain ready flag pulls low.

After both supplies are good and enable is high, the sequencer waits out an enable delay. It then enables precharge and watches the bus. It connects when side A has stayed high for an idle interval. It also connects on a stop condition (side-A data rising while side-A clock is high) if both side-B lines are high at that moment. A supply fault or enable going low takes every output to its off state in the same cycle, and the start-up sequence then begins again. Both intervals are parameters counted in clock cycles.

Top module: `hotswap_conn_seq`

## Requirements
- R1: While reset is active, or in any cycle in which vcc_a_ok or vcc_b_ok is 0, link_on, prechg_on and accel_ok are 0 and rdy_low is 1. Stop patterns on side A during this time do not connect the buffer.
- R2: In the cycle in which en is 0, link_on, prechg_on and accel_ok are 0 and rdy_low is 1, without waiting for a clock edge.
- R3: With both supplies good, the first rising edge that samples en high starts the enable wait. The enable wait lasts EN_DLY_CYC+1 cycles, and prechg_on stays 0 throughout it.
- R4: prechg_on is 1 only in the detect state that follows the enable wait. It is 0 once link_on is 1.
- R5: With side A high throughout, link_on becomes 1 after rising edge number EN_DLY_CYC+IDLE_CYC+3, counted from the first edge that samples en high.
- R6: If sda_a or scl_a is sampled low during detect, the idle count restarts. link_on then becomes 1 after rising edge number IDLE_CYC+1, counted from the first edge at which both lines are high again.
- R7: In detect, a rising edge that sees sda_a high (it was 0 at the previous edge), scl_a high, and sda_b and scl_b both high sets link_on to 1 right after that edge.
- R8: The same stop pattern with sda_b low does not connect at that edge.
- R9: rdy_low is 0 and accel_ok is 1 exactly while link_on is 1.
- R10: A stop pattern during the enable wait does not connect the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_a_ok | input | 1 | Side-A supply above lockout threshold |
| vcc_b_ok | input | 1 | Side-B supply above lockout threshold |
| en | input | 1 | Buffer enable; 0 = shutdown |
| sda_a | input | 1 | Synchronized data level, side A |
| scl_a | input | 1 | Synchronized clock level, side A |
| sda_b | input | 1 | Synchronized data level, side B |
| scl_b | input | 1 | Synchronized clock level, side B |
| link_on | output | 1 | Connect command to the forwarding logic |
| prechg_on | output | 1 | Precharge source enable |
| accel_ok | output | 1 | Rise-time accelerator permit |
| rdy_low | output | 1 | Ready open-drain pull-down active |

## Verification
The hardest case to reach is a stop condition inside the short detect window, where it must win against the idle timer. The idle timer must not finish first. The bench holds side A low (data low for the stop case, clock low for the idle-restart case) while enable rises. It polls prechg_on to find the first detect cycle, and only then releases the line on a falling clock edge. This puts the stop pattern, the idle restart, and a stop pattern with side B low each in a known cycle.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_ENW  = 2'd1,
    ST_PD   = 2'd2,
    ST_CONN = 2'd3
  } hsc_state_e;
endpackage

// File: rtl/hsc_cnt.sv
module hsc_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  function automatic logic [W-1:0] sat_next(input logic [W-1:0] cur);
    return (cur == LIM) ? cur : cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= sat_next(cnt);
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/hsc_stop_det.sv
module hsc_stop_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  input  logic scl_i,
  input  logic far_hi,
  output logic stop_ok
);
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_q <= 1'b1;
    else        sda_q <= sda_i;
  end

  assign stop_ok = scl_i & sda_i & ~sda_q & far_hi;
endmodule

// File: rtl/hotswap_conn_seq.sv
module hotswap_conn_seq
  import hsc_pkg::*;
#(
  parameter int EN_DLY_CYC = 10750,
  parameter int IDLE_CYC   = 10375
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_a_ok,
  input  logic vcc_b_ok,
  input  logic en,
  input  logic sda_a,
  input  logic scl_a,
  input  logic sda_b,
  input  logic scl_b,
  output logic link_on,
  output logic prechg_on,
  output logic accel_ok,
  output logic rdy_low
);
  hsc_state_e state_q, state_d;
  logic pwr_ok, run_ok;
  logic enw_done, idle_done, idle_ok, stop_ok;
  logic side_a_hi, side_b_hi;

  assign pwr_ok    = vcc_a_ok & vcc_b_ok;
  assign run_ok    = pwr_ok & en;
  assign side_a_hi = sda_a & scl_a;
  assign side_b_hi = sda_b & scl_b;

  hsc_cnt #(.LIMIT(EN_DLY_CYC)) u_enw (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q != ST_ENW),
    .done(enw_done)
  );

  hsc_cnt #(.LIMIT(IDLE_CYC)) u_idle (
    .clk(clk), .rst_n(rst_n),
    .clr((state_q != ST_PD) | ~side_a_hi),
    .done(idle_done)
  );

  hsc_stop_det u_stop (
    .clk(clk), .rst_n(rst_n),
    .sda_i(sda_a), .scl_i(scl_a),
    .far_hi(side_b_hi),
    .stop_ok(stop_ok)
  );

  assign idle_ok = idle_done & side_a_hi;

  always_comb begin
    state_d = state_q;
    if (!run_ok) begin
      state_d = ST_LOCK;
    end else begin
      case (state_q)
        ST_LOCK: state_d = ST_ENW;
        ST_ENW:  if (enw_done) state_d = ST_PD;
        ST_PD:   if (idle_ok || stop_ok) state_d = ST_CONN;
        default: state_d = ST_CONN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCK;
    else        state_q <= state_d;
  end

  assign link_on   = run_ok & (state_q == ST_CONN);
  assign prechg_on = run_ok & (state_q == ST_PD);
  assign accel_ok  = link_on;
  assign rdy_low   = ~link_on;

  // R1
  lockout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (!link_on && !prechg_on));
  // R4
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prechg_on && link_on));
  // R3
  enw_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ENW && state_d == ST_PD) |-> enw_done);
  // R5
  connect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PD && state_d == ST_CONN) |-> (idle_ok || stop_ok));
  // R7
  entry_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONN && $past(state_q) != ST_CONN) |-> $past(state_q) == ST_PD);
endmodule

// File: tb/sim_hotswap_conn_seq.sv
module sim_hotswap_conn_seq;
  localparam int EN_DLY = 20;
  localparam int IDLE   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_a_ok = 1'b1, vcc_b_ok = 1'b1, en = 1'b0;
  logic sda_a = 1'b1, scl_a = 1'b1, sda_b = 1'b1, scl_b = 1'b1;
  logic link_on, prechg_on, accel_ok, rdy_low;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  hotswap_conn_seq #(.EN_DLY_CYC(EN_DLY), .IDLE_CYC(IDLE)) u0 (
    .clk(clk), .rst_n(rst_n), .vcc_a_ok(vcc_a_ok), .vcc_b_ok(vcc_b_ok),
    .en(en), .sda_a(sda_a), .scl_a(scl_a), .sda_b(sda_b), .scl_b(scl_b),
    .link_on(link_on), .prechg_on(prechg_on), .accel_ok(accel_ok),
    .rdy_low(rdy_low)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic go_off();
    @(negedge clk) en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic reach_pd();
    @(negedge clk) en = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      if (prechg_on) break;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset link", link_on, 0);
    chk("R1 reset rdy", rdy_low, 1);
    chk("R1 reset prechg", prechg_on, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_idle_path();
    int n = 0;
    go_off();
    sda_a = 1; scl_a = 1; sda_b = 1; scl_b = 1;
    @(negedge clk) en = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      n++;
      if (n == 5) chk("R3 no prechg in enable wait", prechg_on, 0);
      if (n == EN_DLY + 1) chk("R3 enable wait end", prechg_on, 0);
      if (n == EN_DLY + 2) chk("R4 prechg in detect", prechg_on, 1);
      if (link_on) break;
    end
    chk("R5 idle connect edge", n, EN_DLY + IDLE + 3);
    chk("R4 prechg off when linked", prechg_on, 0);
    chk("R9 rdy released", rdy_low, 0);
    chk("R9 accel permit", accel_ok, 1);
  endtask

  task automatic t_en_low();
    @(negedge clk) en = 1'b0;
    #1;
    chk("R2 link off", link_on, 0);
    chk("R2 accel off", accel_ok, 0);
    chk("R2 rdy low", rdy_low, 1);
    chk("R2 prechg off", prechg_on, 0);
  endtask

  task automatic t_stop();
    go_off();
    scl_a = 1; sda_a = 0; sda_b = 1; scl_b = 1;
    reach_pd();
    chk("R7 not linked before stop", link_on, 0);
    sda_a = 1'b1;
    @(posedge clk); #1;
    chk("R7 stop connects", link_on, 1);
    chk("R9 rdy after stop", rdy_low, 0);
  endtask

  task automatic t_stop_blocked();
    go_off();
    scl_a = 1; sda_a = 0; sda_b = 0; scl_b = 1;
    reach_pd();
    sda_a = 1'b1;
    @(posedge clk); #1;
    chk("R8 stop with side B low", link_on, 0);
    chk("R9 rdy held", rdy_low, 1);
    @(negedge clk) sda_b = 1'b1;
  endtask

  task automatic t_stop_enw();
    go_off();
    scl_a = 1; sda_a = 0; sda_b = 1; scl_b = 1;
    @(negedge clk) en = 1'b1;
    repeat (3) @(negedge clk);
    sda_a = 1'b1;
    @(posedge clk); #1;
    chk("R10 stop in enable wait", link_on, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R10 still waiting", link_on, 0);
  endtask

  task automatic t_idle_restart();
    int n = 0;
    go_off();
    scl_a = 0; sda_a = 1; sda_b = 1; scl_b = 1;
    reach_pd();
    repeat (3) @(negedge clk);
    chk("R6 held by low clock", link_on, 0);
    scl_a = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      n++;
      if (link_on) break;
    end
    chk("R6 idle restart edge", n, IDLE + 1);
  endtask

  task automatic t_lockout();
    t_stop();
    @(negedge clk) vcc_b_ok = 1'b0;
    #1;
    chk("R1 lockout link", link_on, 0);
    chk("R1 lockout rdy", rdy_low, 1);
    chk("R1 lockout accel", accel_ok, 0);
    @(negedge clk) sda_a = 1'b0;
    @(negedge clk) sda_a = 1'b1;
    @(posedge clk); #1;
    chk("R1 stop ignored in lockout", link_on, 0);
    chk("R1 no prechg in lockout", prechg_on, 0);
    @(negedge clk) vcc_b_ok = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 restart after lockout link", link_on, 0);
    chk("R1 restart after lockout prechg", prechg_on, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_path();
    t_en_low();
    t_stop();
    t_stop_blocked();
    t_stop_enw();
    t_idle_restart();
    t_lockout();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule